// File: doc/BRIEF.md
# Lane Alignment Receiver Controller

This block brings up one receive lane of a high-speed converter link. It sits after the 8B/10B decoder. On every link clock it takes a word of decoded octets, and each octet comes with a control-character flag and two error flags. The block drives the active-low synchronization request back to the transmitter. It hunts for an unbroken run of comma characters, then confirms code-group synchronization over a few more clean characters. It then waits for the first character that is not a comma, which marks the start of the initial lane alignment sequence.

Inside that sequence the block counts multiframe-closing markers. It captures the configuration octets carried in the second multiframe into a packed register set. After the last multiframe closes, it marks the first user data word with a single-cycle strobe. Octets inside a word are handled in arrival order, lowest byte lane first. Every control character can therefore sit at any byte position of the word.

Top module: `lalign_rx`

## Requirements
- R1: While reset is held, syncReqN, cgsDone, frameLocked, linkUp, cfgValid, userValid and errSticky are 0, and cfgWords and dataOut are all zero.
- R2: A comma is octet 0xBC with its control flag set; 0xBC without the flag is plain data. Octet k of a word occupies bits [8k+7:8k] and is handled before octet k+1. syncReqN rises after the clock edge that samples the word holding the K_RUN-th (4th) consecutive clean comma.
- R3: During the comma hunt, an octet that is not a comma restarts the run count. So does an octet with a not-in-table or disparity error. syncReqN stays low in both cases.
- R4: cgsDone rises once CGS_CHARS (4) further octets have arrived without error after the request is released. An error after release but before the sequence starts drops the lane back to the comma hunt, and syncReqN falls again.
- R5: frameLocked rises after the edge that samples the first non-comma octet that follows cgsDone. That octet is the first /R/ of the alignment sequence.
- R6: After the first closing marker /A/ (0x7C with control flag), the octet following /R/ (0x1C, control) and then /Q/ (0x9C, control) is the first configuration octet. /R/ may fall in any byte position. The next CFG_OCTETS (14) octets are stored. Octet j lands in bits [8j+7:8j] of cfgWords, so word j/4 holds it at byte j%4. Unused high bytes read zero. cfgValid rises once all of them are stored.
- R7: The MF_COUNT-th (4th) /A/ ends the sequence, and linkUp rises after the edge that samples it. userValid is high for exactly one cycle, one cycle after the next input word is sampled, while dataOut holds that word.
- R8: dataOut is the input word sampled at the previous clock edge.
- R9: Decode or disparity errors during the alignment sequence or user data have no effect: errSticky, linkUp and the captured configuration are unchanged.
- R10: errSticky is set by any decode or disparity error seen before the alignment sequence starts. It stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxOctets | input | 8*LANE_OCTETS | Decoded octets, octet 0 in the low byte |
| rxCtrl | input | LANE_OCTETS | Control-character flag per octet |
| rxNotInTable | input | LANE_OCTETS | Not-in-table decode error per octet |
| rxDispErr | input | LANE_OCTETS | Running-disparity error per octet |
| syncReqN | output | 1 | Active-low synchronization request to transmitter |
| cgsDone | output | 1 | Code-group synchronization complete |
| frameLocked | output | 1 | Alignment sequence started (frame data state) |
| linkUp | output | 1 | Alignment sequence finished, user data flowing |
| cfgValid | output | 1 | All configuration octets captured |
| cfgWords | output | 32*CFG_WORDS | Packed configuration octets |
| userValid | output | 1 | One-cycle marker of the first user data word |
| dataOut | output | 8*LANE_OCTETS | Registered copy of the input word |
| errSticky | output | 1 | Sticky decode/disparity error flag from synchronization |

## Verification
The bench builds the block with four octets per word, a comma run and confirmation count of four each, four alignment multiframes and fourteen configuration octets. Under these values a full sequence takes only about twenty words. That makes it cheap to repeat the sequence with the first /R/ placed at each of the four byte positions, so capture and start-of-data are exercised across every alignment. The same short counts let single words hit the corner cases. One word can end a comma run on its last octet. One word can break a run with an unflagged 0xBC. One word can both fall back to the hunt and start a new run.

// File: rtl/lalign_pkg.sv
package lalign_pkg;

  localparam logic [7:0] SYM_COMMA  = 8'hBC;
  localparam logic [7:0] SYM_START  = 8'h1C;
  localparam logic [7:0] SYM_CFGMK  = 8'h9C;
  localparam logic [7:0] SYM_MFEND  = 8'h7C;

  typedef enum logic [2:0] {
    ST_HUNT  = 3'd0,
    ST_CGS   = 3'd1,
    ST_KWAIT = 3'd2,
    ST_ILA   = 3'd3,
    ST_DATA  = 3'd4
  } linkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic errHit;     // error seen during synchronization this cycle
    logic firstWord;  // current input word is the first user data word
  } laneStrobe_t;

endpackage

// File: rtl/lalign_datapath.sv
module lalign_datapath
  import lalign_pkg::*;
#(
  parameter int LANE_OCTETS = 4,
  parameter int CFG_OCTETS  = 14,
  parameter int IW          = 4,
  parameter int CFG_WORDS   = 4
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [8*LANE_OCTETS-1:0]            rxOctets,
  input  logic [LANE_OCTETS-1:0]              rxCtrl,
  input  logic [LANE_OCTETS-1:0]              rxNotInTable,
  input  logic [LANE_OCTETS-1:0]              rxDispErr,
  input  laneStrobe_t                         stb,
  input  logic [LANE_OCTETS-1:0]              capEn,
  input  logic [LANE_OCTETS-1:0][IW-1:0]      capIdx,
  output logic [LANE_OCTETS-1:0]              isComma,
  output logic [LANE_OCTETS-1:0]              isStart,
  output logic [LANE_OCTETS-1:0]              isCfgMark,
  output logic [LANE_OCTETS-1:0]              isMfEnd,
  output logic [LANE_OCTETS-1:0]              isErr,
  output logic [32*CFG_WORDS-1:0]             cfgWords,
  output logic                                userValid,
  output logic [8*LANE_OCTETS-1:0]            dataOut,
  output logic                                errSticky
);

  logic [7:0] cfgOct [CFG_OCTETS];

  // per-octet character classification
  for (genvar o = 0; o < LANE_OCTETS; o++) begin : g_class
    logic [7:0] oct;
    assign oct          = rxOctets[8*o +: 8];
    assign isComma[o]   = rxCtrl[o] && (oct == SYM_COMMA);
    assign isStart[o]   = rxCtrl[o] && (oct == SYM_START);
    assign isCfgMark[o] = rxCtrl[o] && (oct == SYM_CFGMK);
    assign isMfEnd[o]   = rxCtrl[o] && (oct == SYM_MFEND);
    assign isErr[o]     = rxNotInTable[o] | rxDispErr[o];
  end

  // configuration octet store
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int j = 0; j < CFG_OCTETS; j++) cfgOct[j] <= 8'h00;
    end else begin
      for (int o = 0; o < LANE_OCTETS; o++) begin
        if (capEn[o] && (capIdx[o] < IW'(CFG_OCTETS)))
          cfgOct[capIdx[o]] <= rxOctets[8*o +: 8];
      end
    end
  end

  for (genvar j = 0; j < CFG_WORDS*4; j++) begin : g_pack
    if (j < CFG_OCTETS) begin : g_used
      assign cfgWords[8*j +: 8] = cfgOct[j];
    end else begin : g_pad
      assign cfgWords[8*j +: 8] = 8'h00;
    end
  end

  // output word, first-data marker and sticky error
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut   <= '0;
      userValid <= 1'b0;
      errSticky <= 1'b0;
    end else begin
      dataOut   <= rxOctets;
      userValid <= stb.firstWord;
      if (stb.errHit) errSticky <= 1'b1;
    end
  end

endmodule

// File: rtl/lalign_control.sv
module lalign_control
  import lalign_pkg::*;
#(
  parameter int LANE_OCTETS = 4,
  parameter int K_RUN       = 4,
  parameter int CGS_CHARS   = 4,
  parameter int MF_COUNT    = 4,
  parameter int CFG_OCTETS  = 14,
  parameter int IW          = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [LANE_OCTETS-1:0]          isComma,
  input  logic [LANE_OCTETS-1:0]          isStart,
  input  logic [LANE_OCTETS-1:0]          isCfgMark,
  input  logic [LANE_OCTETS-1:0]          isMfEnd,
  input  logic [LANE_OCTETS-1:0]          isErr,
  output laneStrobe_t                     stb,
  output logic [LANE_OCTETS-1:0]          capEn,
  output logic [LANE_OCTETS-1:0][IW-1:0]  capIdx,
  output logic                            syncReqN,
  output logic                            cgsDone,
  output logic                            frameLocked,
  output logic                            linkUp,
  output logic                            cfgValid
);

  localparam int KW = $clog2(K_RUN + 1);
  localparam int CW = $clog2(CGS_CHARS + 1);
  localparam int AW = $clog2(MF_COUNT + 1);

  linkState_t    stReg, nSt;
  logic [KW-1:0] kRun, nK;
  logic [CW-1:0] cgsCnt, nCnt;
  logic [AW-1:0] mfCnt, nMf;
  logic [IW-1:0] capCnt, nCap;
  logic          seenStart, nSeen;
  logic          capOn, nCapOn;
  logic          cfgDone, nCfg;
  logic          firstPend, nPend;
  logic          errHitC;

  // walk the octets of this word in arrival order
  always_comb begin
    nSt    = stReg;
    nK     = kRun;
    nCnt   = cgsCnt;
    nMf    = mfCnt;
    nCap   = capCnt;
    nSeen  = seenStart;
    nCapOn = capOn;
    nCfg   = cfgDone;
    nPend  = 1'b0;
    errHitC = 1'b0;
    capEn  = '0;
    capIdx = '0;
    for (int o = 0; o < LANE_OCTETS; o++) begin
      case (nSt)
        ST_HUNT: begin
          if (isErr[o]) begin
            nK = '0;
            errHitC = 1'b1;
          end else if (isComma[o]) begin
            if (nK == KW'(K_RUN - 1)) begin
              nSt  = ST_CGS;
              nK   = '0;
              nCnt = '0;
            end else begin
              nK = nK + 1'b1;
            end
          end else begin
            nK = '0;
          end
        end
        ST_CGS: begin
          if (isErr[o]) begin
            nSt = ST_HUNT;
            nK  = '0;
            errHitC = 1'b1;
          end else if (nCnt == CW'(CGS_CHARS - 1)) begin
            nSt = ST_KWAIT;
          end else begin
            nCnt = nCnt + 1'b1;
          end
        end
        ST_KWAIT: begin
          if (isErr[o]) begin
            nSt = ST_HUNT;
            nK  = '0;
            errHitC = 1'b1;
          end else if (!isComma[o]) begin
            nSt    = ST_ILA;
            nMf    = '0;
            nSeen  = 1'b0;
            nCapOn = 1'b0;
          end
        end
        ST_ILA: begin
          if (isMfEnd[o]) begin
            nCapOn = 1'b0;
            nSeen  = 1'b0;
            if (nMf == AW'(MF_COUNT - 1)) begin
              nSt   = ST_DATA;
              nPend = 1'b1;
            end else begin
              nMf = nMf + 1'b1;
            end
          end else if (nCapOn) begin
            capEn[o]  = 1'b1;
            capIdx[o] = nCap;
            if (nCap == IW'(CFG_OCTETS - 1)) begin
              nCapOn = 1'b0;
              nCfg   = 1'b1;
            end else begin
              nCap = nCap + 1'b1;
            end
          end else if ((nMf == AW'(1)) && !nCfg) begin
            if (isStart[o]) begin
              nSeen = 1'b1;
            end else if (isCfgMark[o] && nSeen) begin
              nCapOn = 1'b1;
              nCap   = '0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stReg     <= ST_HUNT;
      kRun      <= '0;
      cgsCnt    <= '0;
      mfCnt     <= '0;
      capCnt    <= '0;
      seenStart <= 1'b0;
      capOn     <= 1'b0;
      cfgDone   <= 1'b0;
      firstPend <= 1'b0;
    end else begin
      stReg     <= nSt;
      kRun      <= nK;
      cgsCnt    <= nCnt;
      mfCnt     <= nMf;
      capCnt    <= nCap;
      seenStart <= nSeen;
      capOn     <= nCapOn;
      cfgDone   <= nCfg;
      firstPend <= nPend;
    end
  end

  assign stb.errHit    = errHitC;
  assign stb.firstWord = firstPend;

  assign syncReqN    = (stReg != ST_HUNT);
  assign cgsDone     = (stReg == ST_KWAIT) || (stReg == ST_ILA) || (stReg == ST_DATA);
  assign frameLocked = (stReg == ST_ILA) || (stReg == ST_DATA);
  assign linkUp      = (stReg == ST_DATA);
  assign cfgValid    = cfgDone;

endmodule

// File: rtl/lalign_rx.sv
module lalign_rx
  import lalign_pkg::*;
#(
  parameter int LANE_OCTETS = 4,
  parameter int K_RUN       = 4,
  parameter int CGS_CHARS   = 4,
  parameter int MF_COUNT    = 4,
  parameter int CFG_OCTETS  = 14,
  localparam int CFG_WORDS  = (CFG_OCTETS + 3) / 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [8*LANE_OCTETS-1:0]   rxOctets,
  input  logic [LANE_OCTETS-1:0]     rxCtrl,
  input  logic [LANE_OCTETS-1:0]     rxNotInTable,
  input  logic [LANE_OCTETS-1:0]     rxDispErr,
  output logic                       syncReqN,
  output logic                       cgsDone,
  output logic                       frameLocked,
  output logic                       linkUp,
  output logic                       cfgValid,
  output logic [32*CFG_WORDS-1:0]    cfgWords,
  output logic                       userValid,
  output logic [8*LANE_OCTETS-1:0]   dataOut,
  output logic                       errSticky
);

  localparam int IW = $clog2(CFG_OCTETS + 1);

  laneStrobe_t                    stb;
  logic [LANE_OCTETS-1:0]         capEn;
  logic [LANE_OCTETS-1:0][IW-1:0] capIdx;
  logic [LANE_OCTETS-1:0]         isComma, isStart, isCfgMark, isMfEnd, isErr;

  lalign_datapath #(
    .LANE_OCTETS(LANE_OCTETS), .CFG_OCTETS(CFG_OCTETS),
    .IW(IW), .CFG_WORDS(CFG_WORDS)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .rxOctets(rxOctets), .rxCtrl(rxCtrl),
    .rxNotInTable(rxNotInTable), .rxDispErr(rxDispErr),
    .stb(stb), .capEn(capEn), .capIdx(capIdx),
    .isComma(isComma), .isStart(isStart), .isCfgMark(isCfgMark),
    .isMfEnd(isMfEnd), .isErr(isErr),
    .cfgWords(cfgWords), .userValid(userValid),
    .dataOut(dataOut), .errSticky(errSticky)
  );

  lalign_control #(
    .LANE_OCTETS(LANE_OCTETS), .K_RUN(K_RUN), .CGS_CHARS(CGS_CHARS),
    .MF_COUNT(MF_COUNT), .CFG_OCTETS(CFG_OCTETS), .IW(IW)
  ) u_ctl (
    .clk(clk), .rstN(rstN),
    .isComma(isComma), .isStart(isStart), .isCfgMark(isCfgMark),
    .isMfEnd(isMfEnd), .isErr(isErr),
    .stb(stb), .capEn(capEn), .capIdx(capIdx),
    .syncReqN(syncReqN), .cgsDone(cgsDone), .frameLocked(frameLocked),
    .linkUp(linkUp), .cfgValid(cfgValid)
  );

endmodule

// File: rtl/lalign_rx_checker.sv
module lalign_rx_checker (
  input logic clk,
  input logic rstN,
  input logic syncReqN,
  input logic cgsDone,
  input logic frameLocked,
  input logic linkUp,
  input logic cfgValid,
  input logic userValid,
  input logic errSticky
);

  // request is released whenever code-group sync is complete
  assert_req_released_R4: assert property (@(posedge clk) disable iff (!rstN)
    cgsDone |-> syncReqN);

  // frame data state only after code-group sync
  assert_lock_after_cgs_R5: assert property (@(posedge clk) disable iff (!rstN)
    frameLocked |-> cgsDone);

  // first-data marker lasts a single cycle
  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    userValid |=> !userValid);

  // marker only while the link is up
  assert_pulse_in_data_R7: assert property (@(posedge clk) disable iff (!rstN)
    userValid |-> linkUp);

  // errors after alignment cannot take the link down
  assert_link_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    linkUp |=> linkUp);

  // captured configuration stays valid
  assert_cfg_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid |=> cfgValid);

  // sticky error holds until reset
  assert_sticky_holds_R10: assert property (@(posedge clk) disable iff (!rstN)
    errSticky |=> errSticky);

endmodule

bind lalign_rx lalign_rx_checker u_chk (
  .clk(clk), .rstN(rstN), .syncReqN(syncReqN), .cgsDone(cgsDone),
  .frameLocked(frameLocked), .linkUp(linkUp), .cfgValid(cfgValid),
  .userValid(userValid), .errSticky(errSticky)
);

// File: tb/lalign_rx_test.sv
`timescale 1ns/1ps
module lalign_rx_test;

  localparam int NOCT = 4;
  localparam int CFGN = 14;
  localparam int NW   = (CFGN + 3) / 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                 rstN = 1'b0;
  logic [8*NOCT-1:0]    rxOctets = '0;
  logic [NOCT-1:0]      rxCtrl = '0, rxNit = '0, rxDisp = '0;
  logic                 syncReqN, cgsDone, frameLocked, linkUp, cfgValid, userValid, errSticky;
  logic [32*NW-1:0]     cfgWords;
  logic [8*NOCT-1:0]    dataOut;

  lalign_rx #(
    .LANE_OCTETS(NOCT), .K_RUN(4), .CGS_CHARS(4), .MF_COUNT(4), .CFG_OCTETS(CFGN)
  ) uut (
    .clk(clk), .rstN(rstN), .rxOctets(rxOctets), .rxCtrl(rxCtrl),
    .rxNotInTable(rxNit), .rxDispErr(rxDisp),
    .syncReqN(syncReqN), .cgsDone(cgsDone), .frameLocked(frameLocked),
    .linkUp(linkUp), .cfgValid(cfgValid), .cfgWords(cfgWords),
    .userValid(userValid), .dataOut(dataOut), .errSticky(errSticky)
  );

  int checks = 0;
  int fails  = 0;

  // behavioural reference state
  int mSt, mK, mCnt, mA, mCapCnt;
  bit mSeenR, mCapOn, mErrHit, mDataStart;
  logic [7:0] eCfg [CFGN];
  bit eCfgValid, eErr, ePend, eUser;
  logic [8*NOCT-1:0] eData;

  int userPulses;
  logic [8*NOCT-1:0] firstSeen;
  bit [10:0] q [$];

  task automatic chk(string tag, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic modelReset();
    mSt = 0; mK = 0; mCnt = 0; mA = 0; mCapCnt = 0;
    mSeenR = 0; mCapOn = 0;
    for (int j = 0; j < CFGN; j++) eCfg[j] = 8'h00;
    eCfgValid = 0; eErr = 0; ePend = 0; eUser = 0; eData = '0;
  endtask

  task automatic mOctet(logic [7:0] b, bit c, bit e);
    bit isK, isR, isQ, isA;
    isK = c && (b == 8'hBC);
    isR = c && (b == 8'h1C);
    isQ = c && (b == 8'h9C);
    isA = c && (b == 8'h7C);
    case (mSt)
      0: begin
        if (e) begin mK = 0; mErrHit = 1; end
        else if (isK) begin
          mK++;
          if (mK == 4) begin mSt = 1; mK = 0; mCnt = 0; end
        end else mK = 0;
      end
      1: begin
        if (e) begin mSt = 0; mK = 0; mErrHit = 1; end
        else begin mCnt++; if (mCnt == 4) mSt = 2; end
      end
      2: begin
        if (e) begin mSt = 0; mK = 0; mErrHit = 1; end
        else if (!isK) begin mSt = 3; mA = 0; mSeenR = 0; mCapOn = 0; end
      end
      3: begin
        if (isA) begin
          mCapOn = 0; mSeenR = 0; mA++;
          if (mA == 4) begin mSt = 4; mDataStart = 1; end
        end else if (mCapOn) begin
          eCfg[mCapCnt] = b; mCapCnt++;
          if (mCapCnt == CFGN) begin mCapOn = 0; eCfgValid = 1; end
        end else if (mA == 1 && !eCfgValid) begin
          if (isR) mSeenR = 1;
          else if (isQ && mSeenR) begin mCapOn = 1; mCapCnt = 0; end
        end
      end
      default: ;
    endcase
  endtask

  task automatic compareAll();
    logic [32*NW-1:0] ew;
    ew = '0;
    for (int j = 0; j < CFGN; j++) ew[8*j +: 8] = eCfg[j];
    chk("R2", "syncReqN", syncReqN, (mSt != 0));
    chk("R4", "cgsDone", cgsDone, (mSt >= 2));
    chk("R5", "frameLocked", frameLocked, (mSt >= 3));
    chk("R7", "linkUp", linkUp, (mSt == 4));
    chk("R7", "userValid", userValid, eUser);
    chk("R8", "dataOut", dataOut, eData);
    chk("R6", "cfgValid", cfgValid, eCfgValid);
    chk("R6", "cfgWords", cfgWords, ew);
    chk("R10", "errSticky", errSticky, eErr);
  endtask

  task automatic stepWord(logic [8*NOCT-1:0] w, logic [NOCT-1:0] c,
                          logic [NOCT-1:0] n, logic [NOCT-1:0] d);
    @(negedge clk);
    rxOctets = w; rxCtrl = c; rxNit = n; rxDisp = d;
    mErrHit = 0; mDataStart = 0;
    for (int o = 0; o < NOCT; o++) mOctet(w[8*o +: 8], c[o], n[o] | d[o]);
    eUser = ePend; ePend = mDataStart; eData = w;
    if (mErrHit) eErr = 1;
    @(posedge clk); #1;
    if (userValid) begin userPulses++; firstSeen = dataOut; end
    compareAll();
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; rxOctets = '0; rxCtrl = '0; rxNit = '0; rxDisp = '0;
    modelReset();
    repeat (2) @(posedge clk);
    #1;
    chk("R1", "reset syncReqN", syncReqN, 1'b0);
    chk("R1", "reset cgsDone", cgsDone, 1'b0);
    chk("R1", "reset frameLocked", frameLocked, 1'b0);
    chk("R1", "reset linkUp", linkUp, 1'b0);
    chk("R1", "reset cfgValid", cfgValid, 1'b0);
    chk("R1", "reset cfgWords", cfgWords, '0);
    chk("R1", "reset userValid", userValid, 1'b0);
    chk("R1", "reset dataOut", dataOut, '0);
    chk("R1", "reset errSticky", errSticky, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    userPulses = 0;
    firstSeen = '0;
  endtask

  task automatic push(logic [7:0] b, bit c, bit n, bit d);
    q.push_back({n, d, c, b});
  endtask

  task automatic flush();
    while (q.size() > 0) begin
      logic [8*NOCT-1:0] w;
      logic [NOCT-1:0] c, n, d;
      w = '0; c = '0; n = '0; d = '0;
      for (int o = 0; o < NOCT; o++) begin
        if (q.size() > 0) begin
          bit [10:0] e;
          e = q.pop_front();
          w[8*o +: 8] = e[7:0]; c[o] = e[8]; d[o] = e[9]; n[o] = e[10];
        end
      end
      stepWord(w, c, n, d);
    end
  endtask

  // full bring-up with the first /R/ at byte position p
  task automatic runLink(int p, bit errIla);
    logic [7:0] cfg [CFGN];
    logic [32*NW-1:0] ew;
    logic [8*NOCT-1:0] fw;
    bit [10:0] snap [$];
    int ia, base;
    doReset();
    repeat (12 + p) push(8'hBC, 1, 0, 0);
    push(8'h1C, 1, 0, 0);
    for (int k = 0; k < 6; k++) push(8'h40 + 8'(k), 0, 0, 0);
    push(8'h7C, 1, 0, 0);
    push(8'h1C, 1, 0, 0);
    push(8'h9C, 1, 0, 0);
    for (int j = 0; j < CFGN; j++) begin
      cfg[j] = 8'(8'h21 * (j + 1) + 16 * p);
      push(cfg[j], 0, 0, 0);
    end
    push(8'h7C, 1, 0, 0);
    push(8'h1C, 1, 0, 0);
    for (int k = 0; k < 6; k++) push(8'h50 + 8'(k), 0, errIla && (k == 2), errIla && (k == 4));
    push(8'h7C, 1, 0, 0);
    push(8'h1C, 1, 0, 0);
    for (int k = 0; k < 6; k++) push(8'h60 + 8'(k), 0, 0, 0);
    ia = q.size();
    push(8'h7C, 1, 0, 0);
    for (int k = 0; k < 12; k++) push(8'hC0 + 8'(k), 0, 0, 0);
    snap = q;
    base = 4 * (ia / 4 + 1);
    fw = '0;
    for (int b = 0; b < NOCT; b++)
      if (base + b < snap.size()) fw[8*b +: 8] = snap[base + b][7:0];
    ew = '0;
    for (int j = 0; j < CFGN; j++) ew[8*j +: 8] = cfg[j];
    flush();
    stepWord('0, '0, '0, '0);
    chk("R7", $sformatf("linkUp at end p=%0d", p), linkUp, 1'b1);
    chk("R6", $sformatf("cfgValid p=%0d", p), cfgValid, 1'b1);
    chk("R6", $sformatf("cfgWords p=%0d", p), cfgWords, ew);
    chk("R6", "cfgWords top bytes zero", cfgWords[127:112], 16'h0000);
    chk("R7", $sformatf("userValid pulse count p=%0d", p), userPulses, 1);
    chk("R7", $sformatf("first data word p=%0d", p), firstSeen, fw);
    if (errIla) begin
      chk("R9", "errSticky after errors in sequence", errSticky, 1'b0);
      chk("R9", "link still up after errors", linkUp, 1'b1);
    end
  endtask

  task automatic runErrors();
    doReset();
    // three commas then an erroneous comma: run restarts, sticky set
    stepWord(32'hBCBCBCBC, 4'hF, 4'b1000, 4'b0000);
    chk("R3", "request held after error", syncReqN, 1'b0);
    chk("R10", "sticky set by hunt error", errSticky, 1'b1);
    // 0xBC without control flag breaks the run
    stepWord(32'hBCBCBCBC, 4'b0111, 4'b0000, 4'b0000);
    chk("R2", "unflagged 0xBC is not a comma", syncReqN, 1'b0);
    stepWord(32'hBCBCBCBC, 4'hF, 4'b0000, 4'b0000);
    chk("R2", "release after four clean commas", syncReqN, 1'b1);
    chk("R4", "cgsDone not yet", cgsDone, 1'b0);
    // disparity error during confirmation: back to hunt
    stepWord(32'hBCBCBCBC, 4'hF, 4'b0000, 4'b0100);
    chk("R4", "request reasserted on confirm error", syncReqN, 1'b0);
    stepWord(32'hBCBCBCBC, 4'hF, 4'b0000, 4'b0000);
    chk("R2", "release after fresh run", syncReqN, 1'b1);
    stepWord(32'hBCBCBCBC, 4'hF, 4'b0000, 4'b0000);
    chk("R4", "cgsDone after four more", cgsDone, 1'b1);
    chk("R5", "not locked on commas", frameLocked, 1'b0);
    stepWord(32'h00001CBC, 4'b0011, 4'b0000, 4'b0000);
    chk("R5", "locked on first non-comma", frameLocked, 1'b1);
    for (int i = 0; i < 5; i++) stepWord(32'h11223344, 4'h0, 4'hF, 4'h0);
    chk("R10", "sticky still set", errSticky, 1'b1);
    chk("R9", "locked despite errors", frameLocked, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    modelReset();
    runLink(0, 0);
    runLink(1, 0);
    runLink(2, 1);
    runLink(3, 0);
    runErrors();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule